// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital sequencer in front of an analog-to-digital converter core. It decides when a conversion begins, when one completes and when one is cancelled. Software programs it through a write strobe that addresses five registers: a channel register that also holds the interrupt enable, a trigger-mode register, a repeat-mode register, a queue-depth register and a compare-value register. It also takes a hardware trigger, a stop-mode request and a status bit that says whether the converter's own asynchronous clock keeps running.

Toward the converter it issues one-cycle start pulses with a channel number, one-cycle cancel pulses, and it accepts a done strobe with result data. An accepted result goes into the result register, raises the completion flag and, if enabled, the interrupt. When the queue depth is nonzero, channel writes fill a channel queue. Once that queue holds the programmed number of entries, the block converts those channels in order.

All interfaces are plain strobes without back-pressure. The converter cannot be stalled, and a start or cancel pulse is never held for an acknowledge. A done strobe must be taken in the cycle it appears or it is lost.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, conv_start, conv_abort, coco, irq and result are all zero and no conversion is running.
- R2: With the depth field zero and software trigger mode (mode register bit 0 = 0), a channel write (wr_sel = 0, channel in wr_data[CH_W-1:0]) with a channel that is not all ones gives a conv_start pulse in the next cycle, with conv_ch equal to the written channel.
- R3: A channel value of all ones never starts a conversion, in any trigger mode or queue mode.
- R4: In hardware trigger mode (wr_sel = 1, bit 0 = 1), a channel write starts nothing. A hw_trig pulse while idle and a valid channel is selected gives conv_start in the next cycle. Triggers that arrive while a conversion runs are ignored.
- R5: A conv_done strobe for a running conversion loads conv_data into result and sets coco in the next cycle.
- R6: irq becomes 1 with coco only if the enable bit (wr_data[7] of the last channel write) is 1 when the flag is set. irq never stays 1 without coco.
- R7: coco and irq clear on a rd_en pulse or on any channel write.
- R8: With repeat mode on (wr_sel = 2, bit 0 = 1), each accepted result starts the next conversion in the same cycle that coco rises, until a cancel occurs.
- R9: With the depth field zero, a channel write during a running conversion gives conv_abort. A valid new channel also gives conv_start with that channel in the same cycle.
- R10: Writes to wr_sel 1 to 4 during a running conversion give conv_abort in the next cycle and start nothing. wr_sel values 5 to 7 have no effect.
- R11: stop_req with aclk_en low cancels a running conversion. stop_req with aclk_en high does not.
- R12: A conv_done strobe is ignored when no conversion runs, when it arrives in the cycle a start pulse is shown, or after a cancel. result and coco are then unchanged.
- R13: With a nonzero depth D (wr_sel = 3, wr_data[DEPTH_W-1:0]), channel writes fill the queue without starting anything. In software mode the first queued channel starts one cycle after the D-th write; in hardware mode it starts on the next trigger. Entries convert in write order. After the last entry the queue empties unless repeat mode wraps back to the first entry.
- R14: With a nonzero depth, a channel write while the sequence runs or the queue is full cancels everything and starts nothing. That write becomes the first entry of a new fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 channel, 1 trigger mode, 2 repeat mode, 3 depth, 4 compare value |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Result read strobe, clears the completion flag |
| hw_trig | input | 1 | Hardware trigger pulse |
| stop_req | input | 1 | Stop-mode request |
| aclk_en | input | 1 | Converter asynchronous clock kept running in stop |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_abort | output | 1 | One-cycle cancel pulse to the converter |
| conv_ch | output | CH_W | Channel for the start pulse |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | RES_W | Converter result |
| result | output | RES_W | Result register |
| coco | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the converter raises conv_done only for a conversion it was asked to run. They also assume that wr_sel, wr_data and the strobes are stable around the sampling edge, and that the programmed depth never exceeds FIFO_DEPTH. The stimulus acts as the converter itself: it pulses done only a cycle or more after a start, or deliberately in a cancelled or idle state to probe the ignore rule. It drives every input on the falling edge and keeps depth values within 1 to FIFO_DEPTH.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int WR_W     = 16;
  localparam int IE_BIT   = 7;
  localparam int MODE_BIT = 0;

  typedef enum logic [2:0] {
    SEL_CHAN  = 3'd0,
    SEL_TRIG  = 3'd1,
    SEL_REPT  = 3'd2,
    SEL_DEPTH = 3'd3,
    SEL_CMPV  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 5,
  parameter int FIFO_DEPTH = 8,
  parameter int DEPTH_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [WR_W-1:0]    wr_data,
  output logic               chan_wr,
  output logic               cfg_wr,
  output logic [CH_W-1:0]    wr_ch,
  output logic [CH_W-1:0]    ch_q,
  output logic               ie_q,
  output logic               hw_mode,
  output logic               rept,
  output logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] DMAX = DEPTH_W'(FIFO_DEPTH);

  logic [DEPTH_W-1:0] depth_req;

  always_comb begin
    chan_wr   = wr_en && (wr_sel == SEL_CHAN);
    cfg_wr    = wr_en && (wr_sel == SEL_TRIG || wr_sel == SEL_REPT ||
                          wr_sel == SEL_DEPTH || wr_sel == SEL_CMPV);
    wr_ch     = wr_data[CH_W-1:0];
    depth_req = wr_data[DEPTH_W-1:0];
    if (depth_req > DMAX) depth_req = DMAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q    <= '1;
      ie_q    <= 1'b0;
      hw_mode <= 1'b0;
      rept    <= 1'b0;
      depth   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CHAN: begin
          ch_q <= wr_data[CH_W-1:0];
          ie_q <= wr_data[IE_BIT];
        end
        SEL_TRIG:  hw_mode <= wr_data[MODE_BIT];
        SEL_REPT:  rept    <= wr_data[MODE_BIT];
        SEL_DEPTH: depth   <= depth_req;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chfifo.sv
module adc_seq_chfifo #(
  parameter int CH_W       = 5,
  parameter int FIFO_DEPTH = 8,
  parameter int DEPTH_W    = 4,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push,
  input  logic [CH_W-1:0]    push_ch,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DEPTH_W-1:0] cnt,
  output logic [CH_W-1:0]    rd_ch
);
  logic [CH_W-1:0]    slot [FIFO_DEPTH];
  logic [DEPTH_W-1:0] wpos;
  logic               wr_ok;

  assign wpos  = flush ? '0 : cnt;
  assign wr_ok = push && (wpos < DEPTH_W'(FIFO_DEPTH));
  assign rd_ch = slot[rd_idx];

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[i] <= '0;
      else if (wr_ok && wpos == DEPTH_W'(i)) slot[i] <= push_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_ok) cnt <= wpos + DEPTH_W'(1);
    else if (flush) cnt <= '0;
  end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
  parameter int CH_W    = 5,
  parameter int DEPTH_W = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_wr,
  input  logic               cfg_wr,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [CH_W-1:0]    ch_q,
  input  logic               hw_mode,
  input  logic               rept,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               stop_abort,
  input  logic               hw_trig,
  input  logic               conv_done,
  input  logic [DEPTH_W-1:0] fifo_cnt,
  input  logic [CH_W-1:0]    fifo_ch,
  output logic               fifo_push,
  output logic               fifo_flush,
  output logic [IDX_W-1:0]   fifo_idx,
  output logic               start_o,
  output logic               abort_o,
  output logic [CH_W-1:0]    ch_o,
  output logic               accept
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic             busy_q, seq_q;
  logic [IDX_W-1:0] rp_q;

  logic q_mode, wr_valid, abort_ev, full, last;
  logic sw_go, hw_go, rpt_go, seq_go, seq_adv, seq_end, start_now;
  logic [CH_W-1:0] ch_n;

  always_comb begin
    q_mode   = depth != '0;
    wr_valid = wr_ch != CH_OFF;
    abort_ev = chan_wr | cfg_wr | stop_abort;
    accept   = conv_done & busy_q & ~start_o & ~abort_ev;
    full     = q_mode & (fifo_cnt == depth);
    last     = (DEPTH_W'(rp_q) + DEPTH_W'(1)) == depth;

    // single-channel operation
    sw_go  = ~q_mode & chan_wr & wr_valid & ~hw_mode & ~stop_abort;
    hw_go  = ~q_mode & hw_mode & hw_trig & (ch_q != CH_OFF) & ~busy_q & ~abort_ev;
    rpt_go = ~q_mode & accept & rept;

    // queued operation
    seq_go  = full & ~seq_q & ~abort_ev & (~hw_mode | hw_trig);
    seq_adv = q_mode & seq_q & accept & (~last | rept);
    seq_end = q_mode & seq_q & accept & last & ~rept;

    start_now = sw_go | hw_go | rpt_go | seq_go | seq_adv;

    fifo_push  = q_mode & chan_wr & wr_valid & ~stop_abort;
    fifo_flush = cfg_wr | stop_abort | seq_end |
                 (q_mode & chan_wr & (~wr_valid | seq_q | full));

    if (abort_ev || seq_go)  fifo_idx = '0;
    else if (seq_adv)        fifo_idx = last ? '0 : rp_q + IDX_W'(1);
    else                     fifo_idx = rp_q;

    if (sw_go)                 ch_n = wr_ch;
    else if (seq_go || seq_adv) ch_n = fifo_ch;
    else                       ch_n = ch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      seq_q   <= 1'b0;
      rp_q    <= '0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
      ch_o    <= '0;
    end else begin
      start_o <= start_now;
      abort_o <= abort_ev & busy_q;
      rp_q    <= fifo_idx;
      if (start_now) ch_o <= ch_n;

      if (abort_ev)       busy_q <= sw_go;
      else if (start_now) busy_q <= 1'b1;
      else if (accept)    busy_q <= 1'b0;

      if (abort_ev || seq_end) seq_q <= 1'b0;
      else if (seq_go)         seq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [RES_W-1:0] data,
  input  logic             rd_en,
  input  logic             clr,
  input  logic             ie,
  output logic [RES_W-1:0] result,
  output logic             coco,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      coco   <= 1'b0;
      irq    <= 1'b0;
    end else if (accept) begin
      result <= data;
      coco   <= 1'b1;
      irq    <= ie;
    end else if (rd_en || clr) begin
      coco <= 1'b0;
      irq  <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 5,
  parameter int RES_W      = 12,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rd_en,
  input  logic             hw_trig,
  input  logic             stop_req,
  input  logic             aclk_en,
  output logic             conv_start,
  output logic             conv_abort,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result,
  output logic             coco,
  output logic             irq
);
  localparam int DEPTH_W = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic               chan_wr, cfg_wr, ie_q, hw_mode, rept, accept;
  logic [CH_W-1:0]    wr_ch, ch_q, fifo_ch;
  logic [DEPTH_W-1:0] depth, fifo_cnt;
  logic               fifo_push, fifo_flush, stop_abort;
  logic [IDX_W-1:0]   fifo_idx;

  assign stop_abort = stop_req & ~aclk_en;

  adc_seq_regs #(.CH_W(CH_W), .FIFO_DEPTH(FIFO_DEPTH), .DEPTH_W(DEPTH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .chan_wr(chan_wr), .cfg_wr(cfg_wr), .wr_ch(wr_ch), .ch_q(ch_q), .ie_q(ie_q),
    .hw_mode(hw_mode), .rept(rept), .depth(depth)
  );

  adc_seq_chfifo #(.CH_W(CH_W), .FIFO_DEPTH(FIFO_DEPTH), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(fifo_push), .push_ch(wr_ch),
    .rd_idx(fifo_idx), .cnt(fifo_cnt), .rd_ch(fifo_ch)
  );

  adc_seq_core #(.CH_W(CH_W), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .cfg_wr(cfg_wr), .wr_ch(wr_ch),
    .ch_q(ch_q), .hw_mode(hw_mode), .rept(rept), .depth(depth),
    .stop_abort(stop_abort), .hw_trig(hw_trig), .conv_done(conv_done),
    .fifo_cnt(fifo_cnt), .fifo_ch(fifo_ch), .fifo_push(fifo_push),
    .fifo_flush(fifo_flush), .fifo_idx(fifo_idx), .start_o(conv_start),
    .abort_o(conv_abort), .ch_o(conv_ch), .accept(accept)
  );

  adc_seq_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .accept(accept), .data(conv_data), .rd_en(rd_en),
    .clr(chan_wr), .ie(ie_q), .result(result), .coco(coco), .irq(irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic             conv_start,
  input logic             conv_abort,
  input logic [CH_W-1:0]  conv_ch,
  input logic             conv_done,
  input logic [RES_W-1:0] result,
  input logic             coco,
  input logic             irq,
  input logic             busy
);
  // R3
  start_ch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_ch != {CH_W{1'b1}});

  // R9
  abort_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> $past(busy));

  // R5
  coco_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coco) |-> $past(conv_done));

  // R6
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> coco);

  // R10
  cfg_write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= 3'd1 && wr_sel <= 3'd4 && busy) |=> conv_abort);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(result));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .conv_start(conv_start), .conv_abort(conv_abort), .conv_ch(conv_ch),
  .conv_done(conv_done), .result(result), .coco(coco), .irq(irq),
  .busy(u_core.busy_q)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CH_W = 3, RES_W = 8, FD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, hw_trig = 0, stop_req = 0, aclk_en = 1, conv_done = 0;
  logic [2:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [RES_W-1:0] conv_data = 0;
  logic conv_start, conv_abort, coco, irq;
  logic [CH_W-1:0] conv_ch;
  logic [RES_W-1:0] result;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W), .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .hw_trig(hw_trig), .stop_req(stop_req), .aclk_en(aclk_en),
    .conv_start(conv_start), .conv_abort(conv_abort), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .result(result),
    .coco(coco), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 0; rd_en = 0; hw_trig = 0; conv_done = 0;
  endtask
  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data); step();
  endtask
  task automatic dn(input int d);
    conv_done = 1; conv_data = RES_W'(d); step();
  endtask
  task automatic conv(input int d);
    step(); dn(d);
  endtask
  task automatic trg();
    hw_trig = 1; step();
  endtask
  task automatic rd();
    rd_en = 1; step();
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int last_res;
    int chs[FD];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", conv_start, 0); chk("R1 abort", conv_abort, 0);
    chk("R1 coco", coco, 0); chk("R1 irq", irq, 0); chk("R1 result", result, 0);
    rst_n = 1; step();
    chk("R1 start after release", conv_start, 0);

    // R2 R5 R6 R7 sweep over every valid channel
    for (int ch = 0; ch < 7; ch++) begin
      int ie = ch & 1;
      int val = (ch * 37 + 5) & 255;
      wr(0, (ie << 7) | ch);
      chk("R2 start", conv_start, 1); chk("R2 ch", conv_ch, ch); chk("R2 abort", conv_abort, 0);
      conv(val);
      chk("R5 coco", coco, 1); chk("R5 result", result, val);
      chk("R6 irq", irq, ie); chk("R5 no restart", conv_start, 0);
      if (ie == 0) rd();
      else begin
        wr(0, 7);
        chk("R3 no start", conv_start, 0); chk("R3 no abort idle", conv_abort, 0);
      end
      chk("R7 coco clear", coco, 0); chk("R7 irq clear", irq, 0);
      last_res = val;
    end

    // R12 done while idle
    dn(99);
    chk("R12 idle coco", coco, 0); chk("R12 idle result", result, last_res);

    // R9 rewrite while busy
    wr(0, 2); wr(0, 5);
    chk("R9 abort", conv_abort, 1); chk("R9 start", conv_start, 1); chk("R9 ch", conv_ch, 5);
    conv(200);
    chk("R9 new result", result, 200);
    wr(0, 3); wr(0, 7);
    chk("R3 abort", conv_abort, 1); chk("R3 start", conv_start, 0);
    dn(11);
    chk("R12 after abort coco", coco, 0); chk("R12 after abort result", result, 200);
    wr(0, 1); dn(50);
    chk("R12 start-cycle done", coco, 0);
    dn(51);
    chk("R5 later done", result, 51);
    rd();

    // R10 config writes abort, unused selects do not
    for (int sel = 1; sel <= 4; sel++) begin
      wr(0, 4); step(); wr(sel, 0);
      chk("R10 abort", conv_abort, 1); chk("R10 no start", conv_start, 0);
      conv(77);
      chk("R10 done dropped", coco, 0);
    end
    for (int sel = 5; sel <= 7; sel++) begin
      wr(0, 4); wr(sel, 1);
      chk("R10 unused no abort", conv_abort, 0);
      conv(80 + sel);
      chk("R10 unused result", result, 80 + sel); chk("R10 unused coco", coco, 1);
    end
    rd();

    // R11 stop
    wr(0, 6); stop_req = 1; step();
    chk("R11 clock kept", conv_abort, 0);
    aclk_en = 0; step();
    chk("R11 stop abort", conv_abort, 1);
    stop_req = 0; aclk_en = 1;
    conv(9);
    chk("R11 done dropped", coco, 0);

    // R8 repeat in software mode
    wr(2, 1); wr(0, 3);
    chk("R8 first start", conv_start, 1);
    for (int k = 0; k < 4; k++) begin
      conv(k + 20);
      chk("R8 restart", conv_start, 1); chk("R8 ch", conv_ch, 3);
      chk("R8 coco", coco, 1); chk("R8 result", result, k + 20);
    end
    wr(4, 0);
    chk("R8 cmpv abort", conv_abort, 1); chk("R8 stop chain", conv_start, 0);
    conv(1);
    chk("R12 chain done dropped", result, 23);
    wr(2, 0);

    // R4 hardware trigger
    wr(1, 1); wr(0, 128 | 2);
    chk("R4 write no start", conv_start, 0);
    trg(); chk("R4 trig start", conv_start, 1); chk("R4 ch", conv_ch, 2);
    trg(); chk("R4 busy trig ignored", conv_start, 0);
    conv(60);
    chk("R4 result", result, 60); chk("R6 irq hw", irq, 1); chk("R4 no auto", conv_start, 0);
    trg(); chk("R4 second trig", conv_start, 1);
    conv(61);
    wr(2, 1); trg(); chk("R8 hw first", conv_start, 1);
    conv(62); chk("R8 hw restart", conv_start, 1);
    wr(2, 0); chk("R8 hw abort", conv_abort, 1);
    wr(0, 7); trg(); chk("R3 hw off", conv_start, 0);
    wr(1, 0);

    // R13 queue sweep over depths
    for (int d = 1; d <= FD; d++) begin
      wr(3, d);
      for (int i = 0; i < d; i++) begin
        chs[i] = (i + d) % 7;
        wr(0, chs[i]);
        chk("R13 fill no start", conv_start, 0);
      end
      step();
      chk("R13 seq start", conv_start, 1); chk("R13 first ch", conv_ch, chs[0]);
      for (int i = 0; i < d; i++) begin
        conv(i * 10 + d);
        chk("R13 result", result, i * 10 + d); chk("R13 coco", coco, 1);
        if (i < d - 1) begin
          chk("R13 next start", conv_start, 1); chk("R13 order", conv_ch, chs[i + 1]);
        end else chk("R13 end", conv_start, 0);
      end
      step(); chk("R13 emptied", conv_start, 0);
    end

    // R13 repeat wraps, R14 rewrite during sequence
    wr(2, 1); wr(3, 2); wr(0, 1); wr(0, 5); step();
    chk("R13 rep start", conv_ch, 1);
    conv(30); chk("R13 rep next", conv_ch, 5);
    conv(31); chk("R13 wrap start", conv_start, 1); chk("R13 wrap ch", conv_ch, 1);
    wr(0, 4);
    chk("R14 abort", conv_abort, 1); chk("R14 no start", conv_start, 0);
    step(); chk("R14 waits refill", conv_start, 0);
    wr(0, 6); chk("R14 still waiting", conv_start, 0);
    step(); chk("R14 resume", conv_start, 1); chk("R14 resume ch", conv_ch, 4);
    wr(2, 0); chk("R14 cfg abort", conv_abort, 1);

    // R13 queue with hardware trigger
    wr(1, 1); wr(3, 2); wr(0, 2); wr(0, 3); step();
    chk("R13 hw waits", conv_start, 0);
    trg(); chk("R13 hw start", conv_start, 1); chk("R13 hw ch", conv_ch, 2);
    conv(40); chk("R13 hw next", conv_ch, 3);
    conv(41); chk("R13 hw end", conv_start, 0); chk("R13 hw result", result, 41);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule